// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Station Address Filtering

This block is a full-duplex asynchronous serial transmitter and receiver. Its frame format is chosen at run time through plain configuration inputs: the number of data bits, the stop field length, and whether a parity bit is present and how it is computed. Data goes out through a single holding register feeding a shift register. A new byte can therefore be written while the previous one is still on the line, and frames leave with no idle time between them.

Received frames are placed in a receive data register along with framing, parity and overrun flags. Both directions take their bit timing from an external baud tick that pulses sixteen times per bit. The receiver samples each bit three times around its centre and takes a majority vote. It also rejects a start edge if the line has already returned high by mid-start.

A multi-drop addressing mode lets one station listen to a shared line. Frames whose top data bit is set are address frames. An address frame is always handed up to the host, and it also decides whether this station is selected. Data frames reach the host only while the station is selected; otherwise they are silently discarded.

Top module: `usart_mp_core`

## Requirements
- R1: The line idles high. A frame is one low start bit, then the data bits least significant first, then the optional parity bit, then the stop bits (high). Each bit lasts 16 baud ticks. `cfg_len` codes 0,1,2,3,4 select 5,6,7,8,9 data bits, and codes above 4 also select 9. `cfg_stop2`=1 sends two stop bits; the receiver checks only the first.
- R2: With `cfg_par_en`=1, the transmitter sends a parity bit after the data. The bit is the XOR of the data bits, inverted when `cfg_par_odd`=1. A received frame whose parity bit disagrees with this rule sets `rx_perr`.
- R3: A received frame whose first stop bit is sampled low sets `rx_ferr`. A frame that is delivered while `rx_valid` is already set, with no read in that cycle, is discarded: `rx_data` keeps the older frame and `rx_ovr` is set.
- R4: A falling edge on `rxd` that is high again at the centre of the start bit is rejected. No frame is produced, and the receiver waits for the next falling edge.
- R5: With `cfg_mp_en`=1, a frame whose highest configured data bit is 1 is an address frame and is always delivered. It selects the station when its lower data bits equal the same low bits of `cfg_addr`, and deselects it otherwise. Data frames (top bit 0) are dropped, with no flag change, unless the station is selected. Clearing `cfg_mp_en` deselects the station and delivers every frame.
- R6: A `tx_write` is accepted only while `tx_empty`=1. Once the shift register is busy, a second write fills the holding register. That frame starts in the cycle after the previous last stop bit ends, so two 8N1 frames have their start edges exactly 160 ticks apart. A `tx_write` while `tx_empty`=0 is ignored.
- R7: `tx_done` rises when the last stop bit ends with the holding register empty. An accepted `tx_write` clears it.
- R8: `rx_valid` rises when a delivered frame is placed in `rx_data`. A one-cycle `rx_read` pulse clears `rx_valid`, `rx_perr`, `rx_ferr` and `rx_ovr`.
- R9: Each received bit is the majority of three samples taken on ticks 7, 8 and 9 of the bit, so a single-tick glitch at the bit centre does not change the received value.
- R10: After reset, `txd`=1, `tx_empty`=1, `tx_done`=0, `rx_valid`=0 and all error flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Baud tick, 16 per bit |
| cfg_len | input | 3 | Data length code (0..4 = 5..9 bits) |
| cfg_stop2 | input | 1 | Two stop bits on transmit |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1, even when 0 |
| cfg_mp_en | input | 1 | Multi-drop address filtering on |
| cfg_addr | input | 8 | Station address |
| tx_data | input | 9 | Byte (or 9-bit word) to send |
| tx_write | input | 1 | Write strobe for tx_data |
| tx_empty | output | 1 | Holding register free |
| tx_done | output | 1 | Transmission finished, nothing pending |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_read | input | 1 | Read strobe for the receive register |
| rx_data | output | 9 | Received word |
| rx_valid | output | 1 | Receive register holds an unread frame |
| rx_perr | output | 1 | Parity error of held frame |
| rx_ferr | output | 1 | Framing error of held frame |
| rx_ovr | output | 1 | A frame was lost while the held one was unread |

## Verification
The hardest case to reach from the ports is the address filter's drop of a data frame. The frame has to be fully and correctly received, yet leave no trace at all. The bench builds this case by looping `txd` back into `rxd` in 9-bit mode. It sends a data frame before any address frame, then a matching address, a data frame, and a non-matching address, and checks after every frame that `rx_valid` has stayed low for dropped frames. False starts, single-tick glitches and broken stop or parity bits cannot come out of the transmitter. For those cases the bench disconnects the loop and drives `rxd` directly, cycle by cycle.

// File: rtl/usart_mp_pkg.sv
package usart_mp_pkg;
    localparam int DMAX  = 9;
    localparam int LEN_W = 3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    // number of data bits for a length code; codes above 4 mean 9 bits
    function automatic logic [3:0] data_len(input logic [LEN_W-1:0] code);
        return (code > 3'd4) ? 4'd9 : 4'(code) + 4'd5;
    endfunction

    function automatic logic [DMAX-1:0] len_mask(input logic [LEN_W-1:0] code);
        logic [DMAX-1:0] m;
        m = '0;
        for (int i = 0; i < DMAX; i++) begin
            if (i < int'(data_len(code))) m[i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/usart_tx.sv
module usart_tx
    import usart_mp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic                 cfg_stop2,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic [DMAX-1:0]      tx_data,
    input  logic                 tx_write,
    output logic                 tx_empty,
    output logic                 tx_done,
    output logic                 txd
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);

    typedef struct packed {
        phase_t          ph;
        logic [CW-1:0]   cnt;
        logic [3:0]      idx;
        logic [DMAX-1:0] sh;
        logic            par;
        logic [DMAX-1:0] hold;
        logic            full;
        logic            done;
    } tx_state_t;

    tx_state_t q, n;
    logic [3:0]      last_idx;
    logic [DMAX-1:0] mask;
    logic            bit_end;

    always_comb begin
        n        = q;
        last_idx = data_len(cfg_len) - 4'd1;
        mask     = len_mask(cfg_len);
        bit_end  = tick && (q.cnt == C_LAST);
        if (q.ph == PH_IDLE) begin
            if (q.full) begin
                n.ph   = PH_START;
                n.cnt  = '0;
                n.sh   = q.hold;
                n.par  = (^q.hold) ^ cfg_par_odd;
                n.full = 1'b0;
            end
        end else if (tick) begin
            n.cnt = bit_end ? '0 : q.cnt + 1'b1;
            if (bit_end) begin
                unique case (q.ph)
                    PH_START: begin
                        n.ph  = PH_DATA;
                        n.idx = '0;
                    end
                    PH_DATA: begin
                        n.sh = q.sh >> 1;
                        if (q.idx == last_idx) begin
                            n.ph  = cfg_par_en ? PH_PAR : PH_STOP;
                            n.idx = '0;
                        end else begin
                            n.idx = q.idx + 4'd1;
                        end
                    end
                    PH_PAR: begin
                        n.ph  = PH_STOP;
                        n.idx = '0;
                    end
                    PH_STOP: begin
                        if (cfg_stop2 && q.idx == 4'd0) begin
                            n.idx = 4'd1;
                        end else if (q.full) begin
                            n.ph   = PH_START;
                            n.sh   = q.hold;
                            n.par  = (^q.hold) ^ cfg_par_odd;
                            n.full = 1'b0;
                        end else begin
                            n.ph   = PH_IDLE;
                            n.done = 1'b1;
                        end
                    end
                    default: n.ph = PH_IDLE;
                endcase
            end
        end
        if (tx_write && !q.full) begin
            n.hold = tx_data & mask;
            n.full = 1'b1;
            n.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
        end else begin
            q <= n;
        end
    end

    always_comb begin
        unique case (q.ph)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = q.sh[0];
            PH_PAR:   txd = q.par;
            default:  txd = 1'b1;
        endcase
    end

    assign tx_empty = !q.full;
    assign tx_done  = q.done;

    AST_LOAD_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_IDLE && q.full) |=> (q.ph == PH_START && !q.full)); // R6
    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.full && tx_write) |=> $stable(q.hold)); // R6
    AST_DONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (q.ph == PH_IDLE)); // R7
endmodule

// File: rtl/usart_rx.sv
module usart_rx
    import usart_mp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic                 cfg_par_en,
    input  logic                 cfg_par_odd,
    input  logic                 rxd,
    output logic                 frm_done,
    output logic [DMAX-1:0]      frm_data,
    output logic                 frm_perr,
    output logic                 frm_ferr
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2 + 1;
    localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] C_MID  = CW'(MID);
    localparam logic [CW-1:0] C_SA   = CW'(MID - 2);
    localparam logic [CW-1:0] C_SB   = CW'(MID - 1);

    typedef struct packed {
        logic            s1;
        logic            s2;
        phase_t          ph;
        logic [CW-1:0]   cnt;
        logic [3:0]      idx;
        logic [DMAX-1:0] sh;
        logic            acc;
        logic            sa;
        logic            sb;
        logic            done;
        logic            perr;
        logic            ferr;
    } rx_state_t;

    rx_state_t q, n;
    logic       line;
    logic       vote;
    logic [3:0] last_idx;

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        n.s1     = rxd;
        n.s2     = q.s1;
        line     = q.s2;
        last_idx = data_len(cfg_len) - 4'd1;
        vote     = (q.sa & q.sb) | (q.sa & line) | (q.sb & line);
        if (tick) begin
            if (q.ph == PH_IDLE) begin
                if (!line) begin
                    n.ph   = PH_START;
                    n.cnt  = CW'(1);
                    n.sh   = '0;
                    n.acc  = 1'b0;
                    n.perr = 1'b0;
                    n.ferr = 1'b0;
                end
            end else begin
                n.cnt = (q.cnt == C_LAST) ? '0 : q.cnt + 1'b1;
                if (q.cnt == C_SA) n.sa = line;
                if (q.cnt == C_SB) n.sb = line;
                if (q.cnt == C_MID) begin
                    unique case (q.ph)
                        PH_START: if (vote) n.ph = PH_IDLE;
                        PH_DATA: begin
                            n.sh[q.idx] = vote;
                            n.acc       = q.acc ^ vote;
                        end
                        PH_PAR:  n.perr = q.acc ^ vote ^ cfg_par_odd;
                        PH_STOP: begin
                            n.done = 1'b1;
                            n.ferr = !vote;
                            n.ph   = PH_IDLE;
                        end
                        default: n.ph = PH_IDLE;
                    endcase
                end
                if (q.cnt == C_LAST) begin
                    unique case (q.ph)
                        PH_START: begin
                            n.ph  = PH_DATA;
                            n.idx = '0;
                        end
                        PH_DATA: begin
                            if (q.idx == last_idx) begin
                                n.ph  = cfg_par_en ? PH_PAR : PH_STOP;
                                n.idx = '0;
                            end else begin
                                n.idx = q.idx + 4'd1;
                            end
                        end
                        PH_PAR:  n.ph = PH_STOP;
                        default: n.ph = q.ph;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
            q.sa <= 1'b1;
            q.sb <= 1'b1;
            q.ph <= PH_IDLE;
        end else begin
            q <= n;
        end
    end

    assign frm_done = q.done;
    assign frm_data = q.sh;
    assign frm_perr = q.perr;
    assign frm_ferr = q.ferr;

    AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_START && tick && q.cnt == C_MID && q.sa && q.sb) |=> (q.ph == PH_IDLE)); // R4
    AST_MAJORITY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DATA && tick && q.cnt == C_MID && q.sa && q.sb) |=> q.sh[$past(q.idx)]); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !frm_done); // R8
endmodule

// File: rtl/usart_rx_hold.sv
module usart_rx_hold
    import usart_mp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic                 cfg_mp_en,
    input  logic [DMAX-2:0]      cfg_addr,
    input  logic                 frm_done,
    input  logic [DMAX-1:0]      frm_data,
    input  logic                 frm_perr,
    input  logic                 frm_ferr,
    input  logic                 rx_read,
    output logic [DMAX-1:0]      rx_data,
    output logic                 rx_valid,
    output logic                 rx_perr,
    output logic                 rx_ferr,
    output logic                 rx_ovr
);
    typedef struct packed {
        logic [DMAX-1:0] data;
        logic            valid;
        logic            perr;
        logic            ferr;
        logic            ovr;
        logic            picked;
    } hold_state_t;

    hold_state_t     q, n;
    logic [3:0]      top;
    logic [DMAX-1:0] amask;
    logic            is_addr;
    logic            match;
    logic            held;
    logic            accept;

    always_comb begin
        n       = q;
        top     = data_len(cfg_len) - 4'd1;
        amask   = len_mask(cfg_len) >> 1;
        is_addr = cfg_mp_en && frm_data[top];
        match   = ((frm_data ^ {1'b0, cfg_addr}) & amask) == '0;
        held    = q.valid && !rx_read;
        accept  = !cfg_mp_en || is_addr || q.picked;
        if (!cfg_mp_en) n.picked = 1'b0;
        if (rx_read) begin
            n.valid = 1'b0;
            n.perr  = 1'b0;
            n.ferr  = 1'b0;
            n.ovr   = 1'b0;
        end
        if (frm_done) begin
            if (is_addr) n.picked = match;
            if (accept) begin
                if (held) begin
                    n.ovr = 1'b1;
                end else begin
                    n.data  = frm_data;
                    n.perr  = frm_perr;
                    n.ferr  = frm_ferr;
                    n.ovr   = 1'b0;
                    n.valid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rx_data  = q.data;
    assign rx_valid = q.valid;
    assign rx_perr  = q.perr;
    assign rx_ferr  = q.ferr;
    assign rx_ovr   = q.ovr;

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_read && !frm_done) |=> (!rx_valid && !rx_ovr && !rx_perr && !rx_ferr)); // R8
    AST_UNADDRESSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && cfg_mp_en && !is_addr && !q.picked && !rx_read)
            |=> ($stable(rx_valid) && $stable(rx_data))); // R5
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !cfg_mp_en && rx_valid && !rx_read) |=> (rx_ovr && $stable(rx_data))); // R3
endmodule

// File: rtl/usart_mp_core.sv
module usart_mp_core
    import usart_mp_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic [2:0]  cfg_len,
    input  logic        cfg_stop2,
    input  logic        cfg_par_en,
    input  logic        cfg_par_odd,
    input  logic        cfg_mp_en,
    input  logic [7:0]  cfg_addr,
    input  logic [8:0]  tx_data,
    input  logic        tx_write,
    output logic        tx_empty,
    output logic        tx_done,
    output logic        txd,
    input  logic        rxd,
    input  logic        rx_read,
    output logic [8:0]  rx_data,
    output logic        rx_valid,
    output logic        rx_perr,
    output logic        rx_ferr,
    output logic        rx_ovr
);
    logic            frm_done;
    logic [DMAX-1:0] frm_data;
    logic            frm_perr;
    logic            frm_ferr;

    usart_tx #(.OVS(OVS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cfg_len    (cfg_len),
        .cfg_stop2  (cfg_stop2),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .tx_data    (tx_data),
        .tx_write   (tx_write),
        .tx_empty   (tx_empty),
        .tx_done    (tx_done),
        .txd        (txd)
    );

    usart_rx #(.OVS(OVS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .rxd        (rxd),
        .frm_done   (frm_done),
        .frm_data   (frm_data),
        .frm_perr   (frm_perr),
        .frm_ferr   (frm_ferr)
    );

    usart_rx_hold u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_len   (cfg_len),
        .cfg_mp_en (cfg_mp_en),
        .cfg_addr  (cfg_addr),
        .frm_done  (frm_done),
        .frm_data  (frm_data),
        .frm_perr  (frm_perr),
        .frm_ferr  (frm_ferr),
        .rx_read   (rx_read),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_perr   (rx_perr),
        .rx_ferr   (rx_ferr),
        .rx_ovr    (rx_ovr)
    );

    AST_TX_IDLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> txd); // R1
endmodule

// File: tb/test_usart_mp_core.sv
module test_usart_mp_core;
    localparam int CLK_P = 10;
    localparam int BIT_C = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic [2:0] cfg_len = 3'd3;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_mp_en = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic [8:0] tx_data = '0;
    logic       tx_write = 1'b0;
    logic       tx_empty, tx_done, txd;
    logic       loop = 1'b1;
    logic       drv = 1'b1;
    logic       rxd;
    logic       rx_read = 1'b0;
    logic [8:0] rx_data;
    logic       rx_valid, rx_perr, rx_ferr, rx_ovr;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nfall = 0;
    int tfall [64];
    logic txd_p = 1'b1;

    assign rxd = loop ? txd : drv;

    always #(CLK_P/2) clk = ~clk;

    usart_mp_core i_usart_mp_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_len(cfg_len), .cfg_stop2(cfg_stop2), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_mp_en(cfg_mp_en), .cfg_addr(cfg_addr),
        .tx_data(tx_data), .tx_write(tx_write), .tx_empty(tx_empty),
        .tx_done(tx_done), .txd(txd), .rxd(rxd), .rx_read(rx_read),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_ovr(rx_ovr)
    );

    always @(posedge clk) begin
        cyc   <= cyc + 1;
        txd_p <= txd;
        if (txd_p && !txd && nfall < 64) begin
            tfall[nfall] <= cyc;
            nfall        <= nfall + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [2:0] len, input logic s2, input logic pe,
                           input logic odd, input logic mp, input logic [7:0] ad);
        @(negedge clk);
        cfg_len = len; cfg_stop2 = s2; cfg_par_en = pe; cfg_par_odd = odd;
        cfg_mp_en = mp; cfg_addr = ad;
    endtask

    task automatic pulse_write(input logic [8:0] d);
        @(negedge clk);
        tx_data = d; tx_write = 1'b1;
        @(negedge clk);
        tx_write = 1'b0;
    endtask

    task automatic tx_send(input logic [8:0] d);
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        tx_data = d; tx_write = 1'b1;
        @(negedge clk);
        tx_write = 1'b0;
    endtask

    task automatic wait_rx(output bit got, input int maxc);
        got = 0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (rx_valid) begin
                got = 1;
                break;
            end
        end
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        rx_read = 1'b1;
        @(negedge clk);
        rx_read = 1'b0;
    endtask

    task automatic raw_bit(input logic v);
        drv = v;
        repeat (BIT_C) @(negedge clk);
    endtask

    // start, 8 data bits LSB first, optional parity, one stop
    task automatic raw_frame8(input logic [7:0] d, input bit pe, input logic pb, input logic stopv);
        raw_bit(1'b0);
        for (int i = 0; i < 8; i++) raw_bit(d[i]);
        if (pe) raw_bit(pb);
        raw_bit(stopv);
        drv = 1'b1;
    endtask

    task automatic t_reset();
        chk(txd === 1'b1 && tx_empty === 1'b1 && tx_done === 1'b0, "R10 tx reset",
            {txd, tx_empty, tx_done}, 3'b110);
        chk(rx_valid === 1'b0 && rx_perr === 1'b0 && rx_ferr === 1'b0 && rx_ovr === 1'b0,
            "R10 rx reset", {rx_valid, rx_perr, rx_ferr, rx_ovr}, 0);
    endtask

    task automatic t_loop(input logic [2:0] len, input logic s2, input logic pe,
                          input logic odd, input logic [8:0] d, input string tag);
        bit got;
        int nb;
        logic [8:0] m;
        nb = (len > 3'd4) ? 9 : int'(len) + 5;
        m = 9'((1 << nb) - 1);
        loop = 1'b1;
        set_cfg(len, s2, pe, odd, 1'b0, 8'h00);
        tx_send(d);
        wait_rx(got, 800);
        chk(got && rx_data == (d & m) && !rx_perr && !rx_ferr && !rx_ovr, tag,
            {rx_perr, rx_ferr, rx_data}, d & m);
        rd_pulse();
        repeat (60) @(negedge clk);
        chk(tx_done === 1'b1, "R7 done after frame", tx_done, 1);
    endtask

    // watch txd at bit centres; R1 bit order and R2 parity on the pin
    task automatic t_shape(input logic [2:0] len, input logic pe, input logic odd,
                           input logic [8:0] d, input string tag);
        int nb, n, base;
        logic [15:0] exp, got;
        bit ok;
        nb = int'(len) + 5;
        set_cfg(len, 1'b0, pe, odd, 1'b0, 8'h00);
        exp = '0; got = '0;
        n = 0;
        exp[n++] = 1'b0;
        for (int i = 0; i < nb; i++) exp[n++] = d[i];
        if (pe) begin
            logic p;
            p = odd;
            for (int i = 0; i < nb; i++) p = p ^ d[i];
            exp[n++] = p;
        end
        exp[n++] = 1'b1;
        base = nfall;
        tx_send(d);
        ok = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (nfall > base) begin
                ok = 1;
                break;
            end
        end
        repeat (7) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            got[i] = txd;
            repeat (BIT_C) @(negedge clk);
        end
        chk(ok && got == exp, tag, got, exp);
        begin
            bit g;
            wait_rx(g, 400);
            rd_pulse();
        end
    endtask

    task automatic t_parity_err();
        bit got;
        loop = 1'b0;
        set_cfg(3'd3, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00);
        raw_frame8(8'h0F, 1, 1'b1, 1'b1);
        wait_rx(got, 100);
        chk(got && rx_perr && !rx_ferr && rx_data == 9'h00F, "R2 parity error flagged",
            {rx_perr, rx_data}, 10'h20F);
        rd_pulse();
        chk(!rx_valid && !rx_perr, "R8 read clears perr", {rx_valid, rx_perr}, 0);
    endtask

    task automatic t_frame_err();
        bit got;
        loop = 1'b0;
        set_cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        raw_frame8(8'h33, 0, 1'b0, 1'b0);
        wait_rx(got, 100);
        chk(got && rx_ferr && rx_data == 9'h033, "R3 framing error", {rx_ferr, rx_data}, 10'h233);
        repeat (40) @(negedge clk);
        rd_pulse();
        chk(!rx_valid && !rx_ferr, "R8 read clears ferr", {rx_valid, rx_ferr}, 0);
        repeat (200) @(negedge clk);
        if (rx_valid) rd_pulse();
    endtask

    task automatic t_overrun();
        bit got;
        loop = 1'b0;
        set_cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        raw_frame8(8'h11, 0, 1'b0, 1'b1);
        raw_frame8(8'h22, 0, 1'b0, 1'b1);
        wait_rx(got, 100);
        chk(got && rx_ovr && rx_data == 9'h011, "R3 overrun keeps first", {rx_ovr, rx_data}, 10'h211);
        rd_pulse();
        chk(!rx_valid && !rx_ovr, "R8 read clears ovr", {rx_valid, rx_ovr}, 0);
    endtask

    task automatic t_false_start();
        bit got;
        loop = 1'b0;
        set_cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        drv = 1'b0;
        repeat (5) @(negedge clk);
        drv = 1'b1;
        wait_rx(got, 300);
        chk(!got, "R4 short low pulse ignored", got, 0);
        raw_frame8(8'h5A, 0, 1'b0, 1'b1);
        wait_rx(got, 100);
        chk(got && rx_data == 9'h05A, "R4 next frame after false start", rx_data, 9'h05A);
        rd_pulse();
    endtask

    task automatic t_glitch();
        bit got;
        loop = 1'b0;
        set_cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        raw_bit(1'b0);
        for (int i = 0; i < 8; i++) begin
            if (i == 3) begin
                drv = 1'b0;
                repeat (8) @(negedge clk);
                drv = 1'b1;
                @(negedge clk);
                drv = 1'b0;
                repeat (7) @(negedge clk);
            end else begin
                raw_bit(1'b0);
            end
        end
        raw_bit(1'b1);
        wait_rx(got, 100);
        chk(got && rx_data == 9'h000 && !rx_ferr, "R9 single-tick glitch voted out", rx_data, 0);
        rd_pulse();
    endtask

    task automatic mp_frame(input logic [8:0] d, input bit expect_rx, input string tag);
        bit got;
        tx_send(d);
        wait_rx(got, 400);
        if (expect_rx) begin
            chk(got && rx_data == d, tag, rx_data, d);
            rd_pulse();
        end else begin
            chk(!got, tag, {got, rx_data}, 0);
        end
    endtask

    task automatic t_mp();
        loop = 1'b1;
        set_cfg(3'd4, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12);
        mp_frame(9'h055, 0, "R5 data dropped before address");
        mp_frame(9'h112, 1, "R5 matching address delivered");
        mp_frame(9'h077, 1, "R5 data delivered when selected");
        mp_frame(9'h133, 1, "R5 other address delivered");
        mp_frame(9'h044, 0, "R5 data dropped after deselect");
        set_cfg(3'd4, 1'b0, 1'b0, 1'b0, 1'b0, 8'h12);
        mp_frame(9'h044, 1, "R5 filter off delivers all");
    endtask

    task automatic t_b2b();
        bit got;
        int base;
        loop = 1'b1;
        set_cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
        base = nfall;
        tx_send(9'h0FF);
        chk(tx_done === 1'b0, "R7 write clears done", tx_done, 0);
        tx_send(9'h0FE);
        chk(tx_empty === 1'b0, "R6 holding full", tx_empty, 0);
        pulse_write(9'h099);
        wait_rx(got, 400);
        chk(got && rx_data == 9'h0FF, "R6 first frame", rx_data, 9'h0FF);
        rd_pulse();
        wait_rx(got, 400);
        chk(got && rx_data == 9'h0FE, "R6 second frame", rx_data, 9'h0FE);
        rd_pulse();
        wait_rx(got, 400);
        chk(!got, "R6 write while full ignored", {got, rx_data}, 0);
        chk(nfall == base + 2 && (tfall[base+1] - tfall[base]) == 10 * BIT_C,
            "R6 no gap between frames", tfall[base+1] - tfall[base], 10 * BIT_C);
        chk(tx_done === 1'b1, "R7 done when nothing pending", tx_done, 1);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_shape(3'd3, 1'b0, 1'b0, 9'h0A5, "R1 8N1 line order");
        t_shape(3'd2, 1'b1, 1'b1, 9'h02A, "R2 odd parity on line");
        t_loop(3'd3, 1'b0, 1'b0, 1'b0, 9'h0A5, "R1 8N1 loop");
        t_loop(3'd0, 1'b0, 1'b0, 1'b0, 9'h015, "R1 5 bit loop");
        t_loop(3'd4, 1'b1, 1'b0, 1'b0, 9'h1C3, "R1 9 bit two stop loop");
        t_loop(3'd2, 1'b0, 1'b1, 1'b0, 9'h055, "R2 even parity loop");
        t_loop(3'd2, 1'b0, 1'b1, 1'b1, 9'h02A, "R2 odd parity loop");
        t_parity_err();
        t_frame_err();
        t_overrun();
        t_false_start();
        t_glitch();
        t_mp();
        t_b2b();
        summary();
        $finish;
    end
endmodule